// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded-Operation Status

This block is the device side of a byte-wide flash bank. It watches synchronous write cycles on a small bus. It recognises the unlock-prefixed command sequences for byte program, sector erase and whole-bank erase, and it starts the matching embedded operation. A parameterised cycle counter stands in for the real program or erase duration. While an operation runs, reads aimed at the busy region return a status byte. The host polls that byte until its top bit shows the expected value, or until the next bit stops inverting.

Each bank has 32 sectors, and the five top address bits pick the sector. The storage behind the bus is a small register model. Each sector keeps `2**OFF_BITS` bytes, indexed by the lowest address bits, and the address bits between the sector field and the offset field alias. A sector erase leaves the other sectors usable. Reads of other sectors return true data, and a byte program into another sector can run alongside the erase. The reset input returns the sequencer to read mode. After reset is released, the bus stays quiet for a fixed recovery window.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A byte program is four writes: AAh with address bits [15:0] = 5555h, 55h with bits [15:0] = 2AAAh, A0h at 5555h, then the data at the target address. Sector = bits [20:16], offset = bits [1:0].
- R2: A program can only clear bits. The stored byte becomes old AND new data.
- R3: A sector erase is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address in the sector. On completion every byte of that sector reads FFh.
- R4: The same first five writes followed by 10h@5555h erase the whole bank to FFh.
- R5: A write that breaks the expected address/data pattern returns the sequencer to read mode. The following data write then changes nothing.
- R6: After the final command write, status is returned for exactly PROG_CYC (program), SECT_CYC (sector erase) or CHIP_CYC (bank erase) reads. A read is a status read when it targets the programmed sector or the erasing region. In the status byte, bit 7 is the complement of bit 7 of the program data (0 during an erase) and bits 5:0 are 0. The next read returns true data.
- R7: Bit 6 of the status byte inverts on every status read.
- R8: During a sector erase, reads of other sectors return stored data, and a program into another sector runs concurrently. A program into the erasing sector, or any erase while an operation runs, is ignored.
- R9: Reset aborts any operation without changing storage and returns the sequencer to read mode. For RECOV_CYC cycles after release, reads return 00h and writes are ignored.
- R10: Read data is registered. It appears one clock edge after the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, returns to read mode |
| busSel | input | 1 | Chip select for the bus cycle |
| busWr | input | 1 | Write strobe (wins over busRd) |
| busRd | input | 1 | Read strobe |
| busAddr | input | 21 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data or status byte |

## Verification
Completion of a byte program and completion of a sector erase can land on the same clock edge, each updating a different sector of storage. The bench launches the erase, then counts cycles so that the program's final write falls exactly program-duration cycles before the erase ends. It reads the programmed byte's status through the whole window and afterwards checks both the programmed byte and every byte of the erased sector. Mid-erase reads of a third sector and an ignored program into the erasing sector are judged in the same run.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef struct packed {
    logic launchProg;
    logic launchSect;
    logic launchChip;
  } fcd_cmd_t;

  typedef enum logic [2:0] {
    S_READ,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERS1,
    S_ERS2,
    S_ERS3
  } fcd_state_t;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_CHIP  = 8'h10;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 progBusy,
  input  logic                 eraseBusy,
  input  logic                 eraseChip,
  input  logic [SECT_BITS-1:0] eraseSector,
  output fcd_cmd_t             cmd
);

  localparam int MATCH_W = ADDR_W - SECT_BITS;
  localparam logic [MATCH_W-1:0] ADDR_A = MATCH_W'(16'h5555);
  localparam logic [MATCH_W-1:0] ADDR_B = MATCH_W'(16'h2AAA);

  fcd_state_t state, nextState;

  logic [SECT_BITS-1:0] tgtSect;
  logic hitA, hitB, progAllowed, allIdle;

  assign tgtSect = busAddr[ADDR_W-1 -: SECT_BITS];
  assign hitA    = (busAddr[MATCH_W-1:0] == ADDR_A);
  assign hitB    = (busAddr[MATCH_W-1:0] == ADDR_B);
  assign allIdle = !progBusy && !eraseBusy;
  assign progAllowed = !progBusy &&
                       (!eraseBusy || (!eraseChip && (tgtSect != eraseSector)));

  function automatic logic isByte(input logic [DATA_W-1:0] d, input logic [7:0] c);
    return d == DATA_W'(c);
  endfunction

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (wrEn) begin
      case (state)
        S_READ: nextState = (isByte(busWdata, C_UNLK1) && hitA) ? S_UNL1 : S_READ;
        S_UNL1: nextState = (isByte(busWdata, C_UNLK2) && hitB) ? S_UNL2 : S_READ;
        S_UNL2: begin
          if (isByte(busWdata, C_PROG) && hitA)       nextState = S_PROG;
          else if (isByte(busWdata, C_ERASE) && hitA) nextState = S_ERS1;
          else                                        nextState = S_READ;
        end
        S_PROG: begin
          nextState      = S_READ;
          cmd.launchProg = progAllowed;
        end
        S_ERS1: nextState = (isByte(busWdata, C_UNLK1) && hitA) ? S_ERS2 : S_READ;
        S_ERS2: nextState = (isByte(busWdata, C_UNLK2) && hitB) ? S_ERS3 : S_READ;
        S_ERS3: begin
          nextState = S_READ;
          if (isByte(busWdata, C_SECT))              cmd.launchSect = allIdle;
          else if (isByte(busWdata, C_CHIP) && hitA) cmd.launchChip = allIdle;
        end
        default: nextState = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_READ;
    else       state <= nextState;
  end

  // R5: the sequencer leaves a terminal step for read mode on every write
  p_terminal_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (state == S_PROG || state == S_ERS3)) |=> (state == S_READ));

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 5,
  parameter int OFF_BITS  = 2,
  parameter int PROG_CYC  = 20,
  parameter int SECT_CYC  = 60,
  parameter int CHIP_CYC  = 100,
  parameter int RECOV_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [SECT_BITS-1:0] accSect,
  input  logic [OFF_BITS-1:0]  accOff,
  input  logic [DATA_W-1:0]    busWdata,
  input  fcd_cmd_t             cmd,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 wrEn,
  output logic                 progBusy,
  output logic                 eraseBusy,
  output logic                 eraseChip,
  output logic [SECT_BITS-1:0] eraseSector
);

  localparam int NUM_SECT   = 1 << SECT_BITS;
  localparam int SECT_WORDS = 1 << OFF_BITS;
  localparam int ERASE_MAX  = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int PCNT_W     = $clog2(PROG_CYC + 1);
  localparam int ECNT_W     = $clog2(ERASE_MAX + 1);
  localparam int RCV_W      = $clog2(RECOV_CYC + 1);

  logic [DATA_W-1:0] mem [NUM_SECT][SECT_WORDS];

  logic [RCV_W-1:0]     recovCnt;
  logic                 ready, rdReq;
  logic [PCNT_W-1:0]    progCnt;
  logic [SECT_BITS-1:0] progSect;
  logic [OFF_BITS-1:0]  progOff;
  logic [DATA_W-1:0]    progData;
  logic [ECNT_W-1:0]    eraseCnt;
  logic                 progDone, eraseDone;
  logic                 progHit, eraseHit, toggle;
  logic [DATA_W-1:0]    statusByte;

  assign ready = (recovCnt == '0);
  assign wrEn  = busSel && busWr && ready;
  assign rdReq = busSel && busRd && !busWr;

  // Recovery window after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      recovCnt <= RCV_W'(RECOV_CYC);
    else if (!ready) recovCnt <= recovCnt - 1'b1;
  end

  // Program engine
  assign progDone = progBusy && (progCnt == PCNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progBusy <= 1'b0;
      progCnt  <= '0;
      progSect <= '0;
      progOff  <= '0;
      progData <= '0;
    end else if (cmd.launchProg) begin
      progBusy <= 1'b1;
      progCnt  <= PCNT_W'(PROG_CYC);
      progSect <= accSect;
      progOff  <= accOff;
      progData <= busWdata;
    end else if (progBusy) begin
      if (progDone) progBusy <= 1'b0;
      progCnt <= progCnt - 1'b1;
    end
  end

  // Erase engine (sector or whole bank)
  assign eraseDone = eraseBusy && (eraseCnt == ECNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBusy   <= 1'b0;
      eraseCnt    <= '0;
      eraseChip   <= 1'b0;
      eraseSector <= '0;
    end else if (cmd.launchSect || cmd.launchChip) begin
      eraseBusy   <= 1'b1;
      eraseCnt    <= cmd.launchChip ? ECNT_W'(CHIP_CYC) : ECNT_W'(SECT_CYC);
      eraseChip   <= cmd.launchChip;
      eraseSector <= accSect;
    end else if (eraseBusy) begin
      if (eraseDone) eraseBusy <= 1'b0;
      eraseCnt <= eraseCnt - 1'b1;
    end
  end

  // Storage model: no reset, contents survive the reset input
  always_ff @(posedge clk) begin
    if (progDone) mem[progSect][progOff] <= mem[progSect][progOff] & progData;
    if (eraseDone) begin
      for (int s = 0; s < NUM_SECT; s++) begin
        for (int w = 0; w < SECT_WORDS; w++) begin
          if (eraseChip || (SECT_BITS'(s) == eraseSector)) mem[s][w] <= '1;
        end
      end
    end
  end

  // Read path with status redirection
  assign progHit  = progBusy && (accSect == progSect);
  assign eraseHit = eraseBusy && (eraseChip || (accSect == eraseSector));

  always_comb begin
    statusByte = '0;
    statusByte[DATA_W-1] = progHit ? ~progData[DATA_W-1] : 1'b0;
    statusByte[DATA_W-2] = toggle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      toggle   <= 1'b0;
    end else if (rdReq) begin
      if (!ready) begin
        busRdata <= '0;
      end else if (progHit || eraseHit) begin
        busRdata <= statusByte;
        toggle   <= ~toggle;
      end else begin
        busRdata <= mem[accSect][accOff];
      end
    end
  end

  // R1: at most one operation is launched per write
  p_one_launch_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.launchProg, cmd.launchSect, cmd.launchChip}));

  // R5: launches only come from an accepted write cycle
  p_launch_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != '0) |-> wrEn);

  // R8: a program never starts on a busy engine or inside the erasing region
  p_prog_launch_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.launchProg |-> (!progBusy && !(eraseBusy && (eraseChip || accSect == eraseSector))));

  // R8: erases start only when both engines are idle
  p_erase_launch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.launchSect || cmd.launchChip) |-> (!progBusy && !eraseBusy));

  // R9: nothing is launched during the recovery window
  p_recovery_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (cmd == '0));

  // R6: the program engine releases after its final counted cycle
  p_prog_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> !progBusy);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 5,
  parameter int OFF_BITS  = 2,
  parameter int PROG_CYC  = 20,
  parameter int SECT_CYC  = 60,
  parameter int CHIP_CYC  = 100,
  parameter int RECOV_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  fcd_cmd_t             cmd;
  logic                 wrEn, progBusy, eraseBusy, eraseChip;
  logic [SECT_BITS-1:0] eraseSector;

  fcd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .busAddr(busAddr), .busWdata(busWdata),
    .progBusy(progBusy), .eraseBusy(eraseBusy), .eraseChip(eraseChip),
    .eraseSector(eraseSector), .cmd(cmd)
  );

  fcd_datapath #(
    .DATA_W(DATA_W), .SECT_BITS(SECT_BITS), .OFF_BITS(OFF_BITS),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .accSect(busAddr[ADDR_W-1 -: SECT_BITS]), .accOff(busAddr[OFF_BITS-1:0]),
    .busWdata(busWdata), .cmd(cmd), .busRdata(busRdata), .wrEn(wrEn),
    .progBusy(progBusy), .eraseBusy(eraseBusy), .eraseChip(eraseChip),
    .eraseSector(eraseSector)
  );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  localparam int PROG_CYC  = 20;
  localparam int SECT_CYC  = 60;
  localparam int CHIP_CYC  = 100;
  localparam int RECOV_CYC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [20:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] expMem [32][4];

  always #4 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [20:0] mk(input int s, input int o);
    logic [4:0] sb = s[4:0];
    logic [1:0] ob = o[1:0];
    return {sb, 14'h0, ob};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [7:0] v);
    busSel = 1'b1; busRd = 1'b1; busAddr = a;
    @(negedge clk);
    v = busRdata;
    busSel = 1'b0; busRd = 1'b0;
  endtask

  task automatic prog_seq(input logic [20:0] a, input logic [7:0] d);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'h80);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55);
  endtask

  // n status reads, then caller reads true data
  task automatic busy_window(input logic [20:0] a, input int n, input logic b7, input string req);
    logic [7:0] v;
    logic prev6 = 1'b0;
    for (int i = 0; i < n; i++) begin
      rd(a, v);
      check(req, v & 8'hBF, {b7, 7'h0});
      if (i > 0) check("R7 toggle", {7'h0, v[6]}, {7'h0, ~prev6});
      prev6 = v[6];
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd4242));
    idle(3);
    rstN = 1'b1;

    // R9 / R10: recovery reads return zero
    for (int i = 0; i < RECOV_CYC; i++) begin
      rd(mk(0, 0), v);
      check("R9 recovery read", v, 8'h00);
    end

    // R4: bank erase
    erase_pre(); wr(21'h05555, 8'h10);
    busy_window(mk(4, 1), CHIP_CYC, 1'b0, "R6 bank erase status");
    for (int s = 0; s < 32; s++)
      for (int o = 0; o < 4; o++) begin
        rd(mk(s, o), v);
        check("R4 bank erased", v, 8'hFF);
        expMem[s][o] = 8'hFF;
      end

    // R1, R2: directed programs
    prog_seq(mk(3, 1), 8'h5A);
    busy_window(mk(3, 1), PROG_CYC, 1'b1, "R6 program status");
    rd(mk(3, 1), v); check("R1 program data", v, 8'h5A);
    prog_seq(mk(3, 1), 8'h0F);
    busy_window(mk(3, 1), PROG_CYC, 1'b1, "R6 program status");
    rd(mk(3, 1), v); check("R2 bits only clear", v, 8'h0A);
    expMem[3][1] = 8'h0A;
    prog_seq(mk(7, 2), 8'h3C);
    busy_window(mk(7, 2), PROG_CYC, 1'b1, "R6 program status");
    rd(mk(7, 2), v); check("R10 read after program", v, 8'h3C);
    expMem[7][2] = 8'h3C;

    // R5: broken sequences
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'h77); wr(mk(3, 1), 8'h00);
    rd(mk(3, 1), v); check("R5 bad command byte", v, 8'h0A);
    wr(21'h05555, 8'hAA); wr(21'h01234, 8'h55); wr(21'h05555, 8'hA0); wr(mk(3, 2), 8'h00);
    rd(mk(3, 2), v); check("R5 bad unlock address", v, 8'hFF);

    // R3 / R8: sector erase with concurrent program completing on the same edge
    erase_pre(); wr(mk(3, 0), 8'h30);
    rd(mk(3, 0), v); check("R6 erase status", v & 8'hBF, 8'h00);
    rd(mk(7, 2), v); check("R8 other sector readable", v, 8'h3C);
    prog_seq(mk(3, 3), 8'h00);
    idle(SECT_CYC - PROG_CYC - 10);
    prog_seq(mk(9, 0), 8'h66);
    busy_window(mk(9, 0), PROG_CYC, 1'b1, "R8 concurrent program status");
    rd(mk(9, 0), v); check("R8 concurrent program data", v, 8'h66);
    expMem[9][0] = 8'h66;
    for (int o = 0; o < 4; o++) begin
      rd(mk(3, o), v); check("R3 sector erased", v, 8'hFF);
      expMem[3][o] = 8'hFF;
    end

    // Random mix
    for (int it = 0; it < 48; it++) begin
      int s, o, sel, k;
      logic [7:0] d;
      s = $urandom % 32; o = $urandom % 4; d = 8'($urandom % 256); sel = $urandom % 8;
      if (sel == 0) begin
        erase_pre(); wr(mk(s, 0), 8'h30);
        busy_window(mk(s, o), SECT_CYC, 1'b0, "R6 sector erase status");
        for (int w = 0; w < 4; w++) expMem[s][w] = 8'hFF;
        rd(mk(s, o), v); check("R3 random erase", v, 8'hFF);
      end else if (sel < 3) begin
        k = $urandom % 3;
        wr(21'h05555, (k == 0) ? 8'hAB : 8'hAA);
        wr(21'h02AAA, (k == 1) ? 8'h54 : 8'h55);
        wr(21'h05555, (k == 2) ? 8'hA1 : 8'hA0);
        wr(mk(s, o), d);
        rd(mk(s, o), v); check("R5 random abort", v, expMem[s][o]);
      end else begin
        prog_seq(mk(s, o), d);
        busy_window(mk(s, o), PROG_CYC, ~d[7], "R6 random program status");
        expMem[s][o] = expMem[s][o] & d;
        rd(mk(s, o), v); check("R2 random program", v, expMem[s][o]);
      end
    end

    // R9: reset mid-operation
    erase_pre(); wr(mk(5, 0), 8'h30);
    busy_window(mk(5, 2), SECT_CYC, 1'b0, "R6 sector erase status");
    prog_seq(mk(5, 2), 8'h00);
    idle(5);
    rstN = 1'b0; idle(3); rstN = 1'b1;
    for (int i = 0; i < RECOV_CYC; i++) begin
      rd(mk(5, 2), v); check("R9 recovery read", v, 8'h00);
    end
    rd(mk(5, 2), v); check("R9 aborted program", v, 8'hFF);

    // R9: writes ignored during recovery
    rstN = 1'b0; idle(2); rstN = 1'b1;
    prog_seq(mk(5, 2), 8'h00);
    for (int i = 0; i < RECOV_CYC - 4; i++) begin
      rd(mk(5, 2), v); check("R9 recovery read", v, 8'h00);
    end
    rd(mk(5, 2), v); check("R9 recovery write ignored", v, 8'hFF);

    // R9: read mode usable again
    prog_seq(mk(5, 2), 8'h00);
    busy_window(mk(5, 2), PROG_CYC, 1'b1, "R6 program status");
    rd(mk(5, 2), v); check("R9 program after reset", v, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule